// File: doc/BRIEF.md
# Transmit Mailbox Priority Tracker

This block watches a bank of transmit mailboxes in a message controller and reports one mailbox index. Software or a refill engine uses that index to choose the mailbox it should load or reuse next. A free mailbox is always preferred, and the lowest-numbered free one is chosen. When no mailbox is free, the block names the pending transmit mailbox that would leave the bus last. That is either the one with the greatest arbitration value, where a larger value means lower priority, or the highest-numbered pending one. A single ordering bit chooses between those two rules.

The mailbox that is on the bus right now is removed from every selection. When no mailbox is free and a transmission completes, the index is loaded with the number of the mailbox that just finished. The result is registered, so outputs reflect the inputs seen at the previous clock edge. A valid flag marks the cycles in which the index is meaningful.

Top module: `tx_mb_tracker`

## Requirements
- R1: While reset is asserted (rst_n low), sel_idx, free_flag and valid_flag all read 0.
- R2: If any mailbox that is not excluded has its mb_inactive bit set, then one cycle later sel_idx is the lowest such mailbox number, and free_flag and valid_flag are both 1. This holds even when tx_done is pulsed in the same cycle.
- R3: If no mailbox is free, tx_done is low and order_by_num is 0, then one cycle later sel_idx is the pending mailbox whose 32-bit unsigned arbitration value is greatest. A pending mailbox has its mb_tx_active bit set and is not excluded. Mailbox i's value sits at mb_arb[32*i +: 32]. Among equal values, the lower mailbox number wins. valid_flag is 1.
- R4: If no mailbox is free, tx_done is low and order_by_num is 1, then one cycle later sel_idx is the highest-numbered pending mailbox, and valid_flag is 1.
- R5: When busy_valid is 1, mailbox busy_idx is excluded: it is neither free nor pending for the R2, R3 and R4 selections.
- R6: If no mailbox is free and tx_done is 1, then one cycle later sel_idx equals tx_done_idx and valid_flag is 1. This takes precedence over R3 and R4.
- R7: If no mailbox is free, none is pending and tx_done is low, then one cycle later sel_idx keeps its previous value and valid_flag is 0.
- R8: One cycle after any input cycle, free_flag is 1 exactly when that cycle had at least one free, non-excluded mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| order_by_num | input | 1 | 0: order by arbitration value; 1: order by mailbox number |
| mb_inactive | input | 32 | Per-mailbox free flag |
| mb_tx_active | input | 32 | Per-mailbox pending-transmit flag |
| mb_arb | input | 1024 | Arbitration values, 32 bits per mailbox, mailbox i at bits 32*i+31..32*i |
| busy_valid | input | 1 | A mailbox is currently on the bus |
| busy_idx | input | 7 | Number of the mailbox on the bus |
| tx_done | input | 1 | One-cycle pulse: a transmission completed |
| tx_done_idx | input | 7 | Mailbox number of the completed transmission |
| sel_idx | output | 7 | Reported mailbox number |
| free_flag | output | 1 | A free mailbox was seen |
| valid_flag | output | 1 | sel_idx is meaningful |

## Verification
Two events can land in the same cycle: a completion pulse and a scan result. A completion pulse can coincide with a cycle that has free mailboxes, or with one where only pending mailboxes remain. The bench provokes both overlaps in directed steps, and it also pulses tx_done at random during long runs in which the free vector is often empty. A behavioural model decides each cycle which rule should win, and every clock is judged against it. A free mailbox must beat the completion, and the completion must beat the priority or number scan. The exclusion of the busy mailbox is mixed into the same cycles, so the bench also covers the overlap where the busy mailbox would otherwise have won.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

   typedef enum logic [1:0] {
      PICK_FREE = 2'd0,
      PICK_DONE = 2'd1,
      PICK_SCAN = 2'd2,
      PICK_NONE = 2'd3
   } pick_e;

endpackage

// File: rtl/mbp_qualify.sv
module mbp_qualify #(
   parameter int NUM_MB = 32,
   parameter int IDX_W  = 7
) (
   input  logic [NUM_MB-1:0] mb_inactive,
   input  logic [NUM_MB-1:0] mb_tx_active,
   input  logic              busy_valid,
   input  logic [IDX_W-1:0]  busy_idx,
   output logic [NUM_MB-1:0] free_vec,
   output logic [NUM_MB-1:0] pend_vec
);

   logic [NUM_MB-1:0] excl;

   for (genvar g = 0; g < NUM_MB; g++) begin : g_mask
      assign excl[g]     = busy_valid && (busy_idx == IDX_W'(g));
      assign free_vec[g] = mb_inactive[g] && !excl[g];
      assign pend_vec[g] = mb_tx_active[g] && !excl[g];
   end

endmodule

// File: rtl/mbp_edge_find.sv
module mbp_edge_find #(
   parameter int NUM_MB   = 32,
   parameter int IDX_W    = 7,
   parameter bit FROM_TOP = 1'b0
) (
   input  logic [NUM_MB-1:0] vec,
   output logic              found,
   output logic [IDX_W-1:0]  idx
);

   assign found = |vec;

   if (FROM_TOP) begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < NUM_MB; i++) begin
            if (vec[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_low
      always_comb begin
         idx = '0;
         for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/mbp_max_tree.sv
module mbp_max_tree #(
   parameter int NUM_MB = 32,
   parameter int ARB_W  = 32,
   parameter int IDX_W  = 7
) (
   input  logic [NUM_MB-1:0]       cand,
   input  logic [NUM_MB*ARB_W-1:0] arb,
   output logic                    found,
   output logic [IDX_W-1:0]        idx
);

   localparam int LVL   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;
   localparam int LEAF  = 1 << LVL;
   localparam int NODES = 2 * LEAF - 1;

   logic [ARB_W-1:0] n_val [NODES];
   logic [IDX_W-1:0] n_idx [NODES];
   logic             n_ok  [NODES];

   for (genvar l = 0; l < LEAF; l++) begin : g_leaf
      if (l < NUM_MB) begin : g_real
         assign n_val[LEAF-1+l] = arb[l*ARB_W +: ARB_W];
         assign n_idx[LEAF-1+l] = IDX_W'(l);
         assign n_ok[LEAF-1+l]  = cand[l];
      end else begin : g_pad
         assign n_val[LEAF-1+l] = '0;
         assign n_idx[LEAF-1+l] = '0;
         assign n_ok[LEAF-1+l]  = 1'b0;
      end
   end

   for (genvar n = 0; n < LEAF - 1; n++) begin : g_node
      logic take_left;
      assign take_left = n_ok[2*n+1] &&
                         (!n_ok[2*n+2] || (n_val[2*n+1] >= n_val[2*n+2]));
      assign n_val[n] = take_left ? n_val[2*n+1] : n_val[2*n+2];
      assign n_idx[n] = take_left ? n_idx[2*n+1] : n_idx[2*n+2];
      assign n_ok[n]  = n_ok[2*n+1] || n_ok[2*n+2];
   end

   assign found = n_ok[0];
   assign idx   = n_idx[0];

endmodule

// File: rtl/tx_mb_tracker.sv
module tx_mb_tracker
   import mbp_pkg::*;
#(
   parameter int NUM_MB = 32,
   parameter int ARB_W  = 32,
   parameter int IDX_W  = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    order_by_num,
   input  logic [NUM_MB-1:0]       mb_inactive,
   input  logic [NUM_MB-1:0]       mb_tx_active,
   input  logic [NUM_MB*ARB_W-1:0] mb_arb,
   input  logic                    busy_valid,
   input  logic [IDX_W-1:0]        busy_idx,
   input  logic                    tx_done,
   input  logic [IDX_W-1:0]        tx_done_idx,
   output logic [IDX_W-1:0]        sel_idx,
   output logic                    free_flag,
   output logic                    valid_flag
);

   if (NUM_MB < 2) begin : g_chk_num
      $error("tx_mb_tracker: NUM_MB must be at least 2");
   end
   if (IDX_W < $clog2(NUM_MB)) begin : g_chk_idx
      $error("tx_mb_tracker: IDX_W too narrow for NUM_MB");
   end
   if (ARB_W < 1) begin : g_chk_arb
      $error("tx_mb_tracker: ARB_W must be positive");
   end

   logic [NUM_MB-1:0] free_vec, pend_vec;
   logic              free_any, hi_any, max_any;
   logic [IDX_W-1:0]  free_idx, hi_idx, max_idx;
   logic              scan_any;
   logic [IDX_W-1:0]  scan_idx;
   pick_e             pick;
   logic [IDX_W-1:0]  nxt_idx;

   mbp_qualify #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_qual (
      .mb_inactive (mb_inactive),
      .mb_tx_active(mb_tx_active),
      .busy_valid  (busy_valid),
      .busy_idx    (busy_idx),
      .free_vec    (free_vec),
      .pend_vec    (pend_vec)
   );

   mbp_edge_find #(.NUM_MB(NUM_MB), .IDX_W(IDX_W), .FROM_TOP(1'b0)) u_low (
      .vec  (free_vec),
      .found(free_any),
      .idx  (free_idx)
   );

   mbp_edge_find #(.NUM_MB(NUM_MB), .IDX_W(IDX_W), .FROM_TOP(1'b1)) u_high (
      .vec  (pend_vec),
      .found(hi_any),
      .idx  (hi_idx)
   );

   mbp_max_tree #(.NUM_MB(NUM_MB), .ARB_W(ARB_W), .IDX_W(IDX_W)) u_tree (
      .cand (pend_vec),
      .arb  (mb_arb),
      .found(max_any),
      .idx  (max_idx)
   );

   always_comb begin
      scan_any = order_by_num ? hi_any : max_any;
      scan_idx = order_by_num ? hi_idx : max_idx;
   end

   always_comb begin
      if (free_any)      pick = PICK_FREE;
      else if (tx_done)  pick = PICK_DONE;
      else if (scan_any) pick = PICK_SCAN;
      else               pick = PICK_NONE;
   end

   always_comb begin
      unique case (pick)
         PICK_FREE: nxt_idx = free_idx;
         PICK_DONE: nxt_idx = tx_done_idx;
         PICK_SCAN: nxt_idx = scan_idx;
         default:   nxt_idx = sel_idx;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_idx    <= '0;
         free_flag  <= 1'b0;
         valid_flag <= 1'b0;
      end else begin
         sel_idx    <= nxt_idx;
         free_flag  <= free_any;
         valid_flag <= (pick != PICK_NONE);
      end
   end

endmodule

// File: rtl/mbp_check.sv
module mbp_check #(
   parameter int NUM_MB = 32,
   parameter int IDX_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_MB-1:0] mb_inactive,
   input logic [NUM_MB-1:0] mb_tx_active,
   input logic              busy_valid,
   input logic [IDX_W-1:0]  busy_idx,
   input logic              tx_done,
   input logic [IDX_W-1:0]  tx_done_idx,
   input logic [IDX_W-1:0]  sel_idx,
   input logic              free_flag,
   input logic              valid_flag
);

   localparam int MB_W = $clog2(NUM_MB);

   logic [NUM_MB-1:0] ok_free, ok_pend;
   logic [NUM_MB-1:0] ok_free_q;
   logic              any_free, any_pend;

   always_comb begin
      for (int i = 0; i < NUM_MB; i++) begin
         ok_free[i] = mb_inactive[i] && !(busy_valid && busy_idx == IDX_W'(i));
         ok_pend[i] = mb_tx_active[i] && !(busy_valid && busy_idx == IDX_W'(i));
      end
   end
   assign any_free = |ok_free;
   assign any_pend = |ok_pend;

   always_ff @(posedge clk) ok_free_q <= ok_free;

   // R8
   a_r8_free_seen: assert property (@(posedge clk) disable iff (!rst_n)
      any_free |=> free_flag);
   a_r8_free_absent: assert property (@(posedge clk) disable iff (!rst_n)
      !any_free |=> !free_flag);

   // R2
   a_r2_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
      any_free |=> (valid_flag && (sel_idx < IDX_W'(NUM_MB)) && ok_free_q[sel_idx[MB_W-1:0]]));

   // R6
   a_r6_done_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_free && tx_done) |=> (valid_flag && sel_idx == $past(tx_done_idx)));

   // R5
   a_r5_busy_skipped: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_valid && !tx_done) |=> !(valid_flag && sel_idx == $past(busy_idx)));

   // R7
   a_r7_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_free && !any_pend && !tx_done) |=> (!valid_flag && $stable(sel_idx)));

endmodule

bind tx_mb_tracker mbp_check #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mb_inactive (mb_inactive),
   .mb_tx_active(mb_tx_active),
   .busy_valid  (busy_valid),
   .busy_idx    (busy_idx),
   .tx_done     (tx_done),
   .tx_done_idx (tx_done_idx),
   .sel_idx     (sel_idx),
   .free_flag   (free_flag),
   .valid_flag  (valid_flag)
);

// File: tb/sim_tx_mb_tracker.sv
module sim_tx_mb_tracker;

   localparam int N  = 32;
   localparam int AW = 32;
   localparam int IW = 7;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          order_by_num;
   logic [N-1:0]  mb_inactive, mb_tx_active;
   logic [N*AW-1:0] mb_arb;
   logic          busy_valid;
   logic [IW-1:0] busy_idx;
   logic          tx_done;
   logic [IW-1:0] tx_done_idx;
   logic [IW-1:0] sel_idx;
   logic          free_flag, valid_flag;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   int    e_idx   = 0;
   bit    e_free  = 0;
   bit    e_valid = 0;
   string e_tag   = "R1";

   always #5 clk = ~clk;

   tx_mb_tracker #(.NUM_MB(N), .ARB_W(AW), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .order_by_num(order_by_num),
      .mb_inactive(mb_inactive), .mb_tx_active(mb_tx_active), .mb_arb(mb_arb),
      .busy_valid(busy_valid), .busy_idx(busy_idx),
      .tx_done(tx_done), .tx_done_idx(tx_done_idx),
      .sel_idx(sel_idx), .free_flag(free_flag), .valid_flag(valid_flag)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: cycles actual=%0d expected<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // Behavioural model: decides the next expected outputs from the driven inputs.
   task automatic model();
      int  lo_free = -1, best = -1, top = -1;
      bit  skip;
      for (int i = N - 1; i >= 0; i--) begin
         skip = busy_valid && (int'(busy_idx) == i);
         if (!skip && mb_inactive[i]) lo_free = i;
      end
      for (int i = 0; i < N; i++) begin
         skip = busy_valid && (int'(busy_idx) == i);
         if (!skip && mb_tx_active[i]) begin
            top = i;
            if (best < 0 || mb_arb[i*AW +: AW] > mb_arb[best*AW +: AW]) best = i;
         end
      end
      if (busy_valid) e_tag = "R5"; else e_tag = "";
      e_free = (lo_free >= 0);
      if (lo_free >= 0) begin
         e_idx = lo_free; e_valid = 1; e_tag = {e_tag, " R2 R8"};
      end else if (tx_done) begin
         e_idx = int'(tx_done_idx); e_valid = 1; e_tag = {e_tag, " R6"};
      end else if (top >= 0) begin
         e_valid = 1;
         if (order_by_num) begin e_idx = top;  e_tag = {e_tag, " R4"}; end
         else              begin e_idx = best; e_tag = {e_tag, " R3"}; end
      end else begin
         e_valid = 0; e_tag = {e_tag, " R7"};
      end
   endtask

   task automatic compare();
      n_chk++;
      if (int'(sel_idx) != e_idx || free_flag != e_free || valid_flag != e_valid) begin
         n_fail++;
         $display("FAIL %s: actual idx=%0d free=%0b valid=%0b expected idx=%0d free=%0b valid=%0b",
                  e_tag, sel_idx, free_flag, valid_flag, e_idx, e_free, e_valid);
      end
   endtask

   // Inputs are set at a falling edge; the result is sampled one full cycle later.
   task automatic step();
      model();
      @(negedge clk);
      compare();
   endtask

   task automatic clear_in();
      order_by_num = 0; mb_inactive = '0; mb_tx_active = '0; mb_arb = '0;
      busy_valid = 0; busy_idx = '0; tx_done = 0; tx_done_idx = '0;
   endtask

   task automatic set_arb(int m, logic [AW-1:0] v);
      mb_arb[m*AW +: AW] = v;
   endtask

   initial begin
      clear_in();
      rst_n = 0;
      repeat (3) @(negedge clk);
      e_idx = 0; e_free = 0; e_valid = 0; e_tag = "R1";
      compare();                       // R1 reset state
      rst_n = 1;

      step();                          // R7: nothing at all
      mb_inactive[5] = 1; mb_inactive[9] = 1;
      step();                          // R2: lowest free is 5
      busy_valid = 1; busy_idx = 7'd5;
      step();                          // R5: 5 busy, so 9
      clear_in();
      mb_tx_active[3] = 1; mb_tx_active[7] = 1; mb_tx_active[20] = 1;
      set_arb(3, 32'd10); set_arb(7, 32'd50); set_arb(20, 32'd50);
      step();                          // R3: tie 7/20 -> 7
      order_by_num = 1;
      step();                          // R4: highest pending is 20
      busy_valid = 1; busy_idx = 7'd20;
      step();                          // R5 with R4: 7
      order_by_num = 0; busy_valid = 0;
      tx_done = 1; tx_done_idx = 7'd12;
      step();                          // R6: completion wins over scan
      mb_inactive[2] = 1;
      step();                          // R2 beats R6: 2
      clear_in();
      step();                          // R7: hold 2, invalid
      mb_tx_active = '1;
      step();                          // R3: all equal -> 0
      order_by_num = 1;
      step();                          // R4: 31
      order_by_num = 0; set_arb(31, 32'hFFFF_FFFF);
      step();                          // R3: max value at 31
      busy_valid = 1; busy_idx = 7'd31;
      step();                          // R5: 31 busy, back to 0
      clear_in(); mb_inactive[31] = 1;
      step();                          // R2: only free is 31

      for (int k = 0; k < 600; k++) begin
         clear_in();
         order_by_num = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 2) == 0)
            for (int i = 0; i < N; i++) mb_inactive[i] = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 7) != 0)
            for (int i = 0; i < N; i++) mb_tx_active[i] = ($urandom_range(0, 2) == 0);
         for (int i = 0; i < N; i++) set_arb(i, AW'($urandom_range(0, 7)));
         busy_valid  = ($urandom_range(0, 1) == 1);
         busy_idx    = IW'($urandom_range(0, N - 1));
         tx_done     = ($urandom_range(0, 3) == 0);
         tx_done_idx = IW'($urandom_range(0, N - 1));
         step();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule